// File: doc/BRIEF.md
# Mixed Page-Size Associative Translation Buffer

This block is a small, fully associative translation lookaside buffer in which every resident entry carries its own page size. Four sizes are available: 8 KB, 64 KB, 512 KB and 4 MB. Entries of any mix of these sizes may be resident at once. Pages are always aligned to their own size. A set index cannot be formed when sizes differ, so every lookup compares the virtual address against all entries in parallel. Each compare uses that entry's own size mask. The low address bits below the page boundary pass through unchanged as the offset.

A lookup presented in one cycle produces a registered result in the next cycle. On a hit, the result is the physical address, which goes on toward the cache. On a miss, the result is an exception-style flag. The requester, either software or a table walker, then writes one entry through the refill port and retries the access.

The refill port picks its victim as follows. It takes the lowest-indexed free slot if one exists. Otherwise it takes the slot chosen by a round-robin pointer, and that pointer steps on every refill. A flush input empties the whole buffer in a single cycle.

Top module: `tlbm_top`

## Requirements
- R1: Size code `fill_size` is 2'b00=8 KB, 2'b01=64 KB, 2'b10=512 KB, 2'b11=4 MB. A valid entry matches when the lookup address equals its stored virtual page on all bits at and above bit 13, 16, 19 or 22 respectively. Address bits below that boundary are ignored, both at refill and at lookup.
- R2: On a hit, `res_pa` holds the entry's physical page bits at and above the boundary, combined with the lookup address bits below the boundary.
- R3: `res_valid` in a cycle equals `lookup_valid` of the previous cycle. All result outputs reflect the buffer contents as they stood before that clock edge.
- R4: A presented lookup with no matching valid entry gives `res_miss`=1, `res_hit`=0 and `res_pa`=0. With no lookup presented, `res_hit`, `res_miss` and `res_multi` are 0.
- R5: A refill writes the lowest-indexed invalid entry when any entry is invalid.
- R6: When all entries are valid, a refill writes the entry named by a round-robin pointer. The pointer resets to 0, advances by one on every accepted refill, and wraps after the last entry. A flush does not change it.
- R7: When several valid entries match, the lowest-indexed one supplies `res_pa` and `res_multi` is 1.
- R8: `flush` invalidates every entry in one cycle. A refill presented in the same cycle as `flush` is dropped and does not advance the pointer.
- R9: A lookup in the same cycle as a refill sees the old contents. The retried lookup in the next cycle sees the new entry.
- R10: During and right after synchronous reset all result outputs are 0 and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_va | input | 32 | Virtual address to translate |
| fill_en | input | 1 | Write one entry |
| fill_va | input | 32 | Virtual page of the new entry |
| fill_pa | input | 32 | Physical page of the new entry |
| fill_size | input | 2 | Page size code of the new entry |
| res_valid | output | 1 | Registered result present |
| res_hit | output | 1 | Translation found |
| res_miss | output | 1 | Miss exception |
| res_multi | output | 1 | More than one entry matched |
| res_pa | output | 32 | Translated physical address |

## Verification
The embedded assertions check the following on every cycle. A result follows every lookup by one cycle. A miss never carries an address. A multi-hit implies a hit. A flush leaves no valid entry. An accepted refill sets the valid bit of the slot it chose and steps the pointer. The remaining behaviours only the bench's scenarios can show: which slot a refill chooses once the buffer is full, the exact size-masked compare at each page boundary, offset passthrough, lowest-index priority among overlapping pages, and the ordering of a refill against a same-cycle lookup or flush.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int N_ENT   = 8;

    typedef enum logic [1:0] {
        PG_8K   = 2'b00,
        PG_64K  = 2'b01,
        PG_512K = 2'b10,
        PG_4M   = 2'b11
    } pg_size_e;

    typedef struct packed {
        logic [VA_W-1:0] vtag;
        logic [PA_W-1:0] pbase;
        pg_size_e        size;
    } tlb_ent_t;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            multi;
        logic [PA_W-1:0] pa;
    } tlb_res_t;

    function automatic int unsigned off_bits(pg_size_e s);
        case (s)
            PG_8K:   return 13;
            PG_64K:  return 16;
            PG_512K: return 19;
            default: return 22;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] va_lo_mask(pg_size_e s);
        logic [VA_W-1:0] one;
        one = {{(VA_W-1){1'b0}}, 1'b1};
        return (one << off_bits(s)) - one;
    endfunction

    function automatic logic [PA_W-1:0] pa_lo_mask(pg_size_e s);
        logic [PA_W-1:0] one;
        one = {{(PA_W-1){1'b0}}, 1'b1};
        return (one << off_bits(s)) - one;
    endfunction
endpackage

// File: rtl/tlbm_match.sv
module tlbm_match
    import tlbm_pkg::*;
(
    input  tlb_ent_t        ent,
    input  logic            ent_valid,
    input  logic [VA_W-1:0] va,
    output logic            hit,
    output logic [PA_W-1:0] pa
);
    logic [VA_W-1:0] vmask;
    logic [PA_W-1:0] pmask;
    logic [PA_W-1:0] va_as_pa;

    always_comb begin
        vmask    = va_lo_mask(ent.size);
        pmask    = pa_lo_mask(ent.size);
        va_as_pa = PA_W'(va);
        hit      = ent_valid && ((va & ~vmask) == (ent.vtag & ~vmask));
        pa       = (ent.pbase & ~pmask) | (va_as_pa & pmask);
    end
endmodule

// File: rtl/tlbm_victim.sv
module tlbm_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic               advance,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_ptr;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        victim = any_free ? free_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_ptr <= '0;
        else if (advance)
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end

    a_r6_ptr_steps: assert property (@(posedge clk) disable iff (rst)
        advance |=> (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + 1'b1)));
    a_r6_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(rr_ptr));
endmodule

// File: rtl/tlbm_top.sv
module tlbm_top
    import tlbm_pkg::*;
#(
    parameter int ENTRIES = N_ENT,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            lookup_valid,
    input  logic [VA_W-1:0] lookup_va,
    input  logic            fill_en,
    input  logic [VA_W-1:0] fill_va,
    input  logic [PA_W-1:0] fill_pa,
    input  logic [1:0]      fill_size,
    output logic            res_valid,
    output logic            res_hit,
    output logic            res_miss,
    output logic            res_multi,
    output logic [PA_W-1:0] res_pa
);
    tlb_ent_t           ents [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [PA_W-1:0]    pa_vec [ENTRIES];
    logic [IDX_W-1:0]   victim;
    logic               fill_ok;
    tlb_res_t           res_d, res_q;
    pg_size_e           new_size;

    assign fill_ok  = fill_en && !flush;
    assign new_size = pg_size_e'(fill_size);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlbm_match u_match (
            .ent       (ents[g]),
            .ent_valid (valid_q[g]),
            .va        (lookup_va),
            .hit       (hit_vec[g]),
            .pa        (pa_vec[g])
        );
    end

    tlbm_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .valid   (valid_q),
        .advance (fill_ok),
        .victim  (victim)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = lookup_valid;
        if (lookup_valid) begin
            res_d.hit   = |hit_vec;
            res_d.miss  = ~(|hit_vec);
            res_d.multi = $countones(hit_vec) > 1;
            for (int i = ENTRIES - 1; i >= 0; i--)
                if (hit_vec[i]) res_d.pa = pa_vec[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    always_ff @(posedge clk) begin
        if (rst || flush)
            valid_q <= '0;
        else if (fill_ok)
            valid_q[victim] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_ok) begin
            ents[victim].vtag  <= fill_va & ~va_lo_mask(new_size);
            ents[victim].pbase <= fill_pa & ~pa_lo_mask(new_size);
            ents[victim].size  <= new_size;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_miss  = res_q.miss;
    assign res_multi = res_q.multi;
    assign res_pa    = res_q.pa;

    a_r3_result_follows: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> res_valid);
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lookup_valid |=> !(res_valid || res_hit || res_miss || res_multi));
    a_r4_miss_no_pa: assert property (@(posedge clk) disable iff (rst)
        res_miss |-> (!res_hit && res_pa == '0));
    a_r7_multi_is_hit: assert property (@(posedge clk) disable iff (rst)
        res_multi |-> res_hit);
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));
    a_r5_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
        fill_ok |=> valid_q[$past(victim)]);
endmodule

// File: tb/tlbm_top_test.sv
module tlbm_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_va = '0;
    logic        fill_en = 1'b0;
    logic [31:0] fill_va = '0;
    logic [31:0] fill_pa = '0;
    logic [1:0]  fill_size = '0;
    logic        res_valid, res_hit, res_miss, res_multi;
    logic [31:0] res_pa;

    always #4 clk = ~clk;

    tlbm_top uut (
        .clk(clk), .rst(rst), .flush(flush),
        .lookup_valid(lookup_valid), .lookup_va(lookup_va),
        .fill_en(fill_en), .fill_va(fill_va), .fill_pa(fill_pa), .fill_size(fill_size),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_multi(res_multi), .res_pa(res_pa)
    );

    // behavioural reference
    logic        m_valid [8];
    logic [31:0] m_va    [8];
    logic [31:0] m_pa    [8];
    int          m_shift [8];
    int          m_ptr;
    logic        e_valid, e_hit, e_miss, e_multi;
    logic [31:0] e_pa;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    done   = 0;
    string ctx    = "R10";

    function automatic int shift_of(logic [1:0] c);
        return (c == 2'd0) ? 13 : (c == 2'd1) ? 16 : (c == 2'd2) ? 19 : 22;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
            m_ptr = 0;
            {e_valid, e_hit, e_miss, e_multi} = '0;
            e_pa = '0;
        end else begin
            int nmatch;
            int v;
            nmatch = 0;
            e_pa = '0;
            for (int i = 0; i < 8; i++) begin
                if (m_valid[i] && ((lookup_va >> m_shift[i]) == (m_va[i] >> m_shift[i]))) begin
                    if (nmatch == 0)
                        e_pa = ((m_pa[i] >> m_shift[i]) << m_shift[i]) |
                               (lookup_va & ((32'h1 << m_shift[i]) - 32'h1));
                    nmatch++;
                end
            end
            e_valid = lookup_valid;
            e_hit   = lookup_valid && nmatch > 0;
            e_miss  = lookup_valid && nmatch == 0;
            e_multi = lookup_valid && nmatch > 1;
            if (!lookup_valid || nmatch == 0) e_pa = '0;
            if (flush) begin
                for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
            end else if (fill_en) begin
                v = -1;
                for (int i = 0; i < 8; i++) if (v < 0 && !m_valid[i]) v = i;
                if (v < 0) v = m_ptr;
                m_valid[v] = 1'b1;
                m_va[v]    = fill_va;
                m_pa[v]    = fill_pa;
                m_shift[v] = shift_of(fill_size);
                m_ptr      = (m_ptr + 1) % 8;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            checks++;
            if (res_valid !== e_valid) begin
                fails++;
                $display("FAIL R3 [%s] res_valid actual %b expected %b", ctx, res_valid, e_valid);
            end else if (res_hit !== e_hit || res_miss !== e_miss) begin
                fails++;
                $display("FAIL R1/R4 [%s] hit/miss actual %b%b expected %b%b va-phase",
                         ctx, res_hit, res_miss, e_hit, e_miss);
            end else if (res_multi !== e_multi) begin
                fails++;
                $display("FAIL R7 [%s] res_multi actual %b expected %b", ctx, res_multi, e_multi);
            end else if (res_pa !== e_pa) begin
                fails++;
                $display("FAIL R2 [%s] res_pa actual %h expected %h", ctx, res_pa, e_pa);
            end
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog actual timeout expected completion");
                done = 1;
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    task automatic cyc(input logic lv, input logic [31:0] va,
                       input logic fe, input logic [31:0] fva, input logic [31:0] fpa,
                       input logic [1:0] fsz, input logic fl);
        @(negedge clk); #1;
        lookup_valid = lv; lookup_va = va;
        fill_en = fe; fill_va = fva; fill_pa = fpa; fill_size = fsz;
        flush = fl;
    endtask

    task automatic look(input logic [31:0] va);
        cyc(1'b1, va, 1'b0, '0, '0, 2'd0, 1'b0);
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
        cyc(1'b0, '0, 1'b1, va, pa, sz, 1'b0);
    endtask

    initial begin
        logic [31:0] lfsr;
        ctx = "R10";
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        cyc(1'b0, '0, 1'b0, '0, '0, 2'd0, 1'b0);

        ctx = "R4 empty";
        look(32'h1234_5678);
        look(32'h0000_0000);

        ctx = "R1 R2 8K";
        fill(32'h0000_4ABC, 32'h8000_2DEF, 2'd0);
        look(32'h0000_4000); look(32'h0000_5FFF); look(32'h0000_6000); look(32'h0000_3FFF);

        ctx = "R1 R2 64K";
        fill(32'h1001_0000, 32'h2003_0000, 2'd1);
        look(32'h1001_FFFF); look(32'h1002_0000); look(32'h1000_FFFF);

        ctx = "R1 R2 512K";
        fill(32'h2008_0000, 32'h4010_0000, 2'd2);
        look(32'h200F_FFFC); look(32'h2007_FFFF); look(32'h2010_0000);

        ctx = "R1 R2 4M";
        fill(32'h3040_0000, 32'h5080_0000, 2'd3);
        look(32'h307F_FFFF); look(32'h3080_0000); look(32'h3041_2345);

        ctx = "R9 retry";
        look(32'h4444_0123);
        cyc(1'b1, 32'h4444_0123, 1'b1, 32'h4444_0000, 32'h9999_0000, 2'd1, 1'b0);
        look(32'h4444_0123);

        ctx = "R7 multi";
        fill(32'h3042_0000, 32'h6000_0000, 2'd0);
        look(32'h3042_0010); look(32'h3042_2010);

        ctx = "R5 fill free";
        fill(32'h5000_0000, 32'h0100_0000, 2'd2);
        fill(32'h6000_0000, 32'h0200_0000, 2'd3);
        look(32'h5001_0000); look(32'h6012_3456);

        ctx = "R6 round robin";
        fill(32'h7000_0000, 32'h0300_0000, 2'd0);
        fill(32'h7100_0000, 32'h0400_0000, 2'd0);
        fill(32'h7200_0000, 32'h0500_0000, 2'd0);
        for (int i = 0; i < 10; i++) begin
            fill(32'h7300_0000 + (i << 24), 32'h0600_0000 + (i << 13), 2'(i));
            look(32'h0000_4100); look(32'h1001_0100); look(32'h7000_0004);
        end

        ctx = "R8 flush";
        cyc(1'b1, 32'h7300_0000, 1'b0, '0, '0, 2'd0, 1'b1);
        look(32'h7300_0000); look(32'h7400_0000);
        cyc(1'b0, '0, 1'b1, 32'h0000_8000, 32'hA000_0000, 2'd0, 1'b1);
        look(32'h0000_8000);
        fill(32'h0000_8000, 32'hA000_0000, 2'd0);
        look(32'h0000_9FFF);

        ctx = "R1 R2 R7 mixed";
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3:0] == 4'd0)
                fill({lfsr[31:28], 4'h0, lfsr[23:0]}, lfsr ^ 32'h5A5A_0000, lfsr[5:4]);
            else
                cyc(1'b1, {lfsr[31:28], 4'h0, lfsr[23:0]}, 1'b0, '0, '0, 2'd0, lfsr[11:4] == 8'hFF);
        end

        cyc(1'b0, '0, 1'b0, '0, '0, 2'd0, 1'b0);
        repeat (2) @(negedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule